// File: doc/BRIEF.md
# Multiplexed Address/Data Register Port

This block connects a host processor with one shared 8-bit address/data bus to the register file of a chip. In the first phase the host puts a register address on the bus and pulses an address strobe high. The value on the bus when that strobe falls is kept as the register address. In the second phase the host pulls the active-low select low together with either the active-low read strobe or the active-low write strobe. The bus pins are split into an input, an output and an output enable.

The host strobes are asynchronous to the block's clock. They pass through a two-flop synchronizer, and the bus data passes through a matching two-flop delay so that it stays aligned with them. A four-state machine then works on the synchronized signals:
- `ST_IDLE` waits for an access.
- `ST_READ` drives the bus.
- `ST_WRITE` collects write data and counts how long the strobe stays low.
- `ST_BLOCK` absorbs an illegal access in which read and write are low together.

The transitions are as follows:
- IDLE→READ happens on select and read low while write is high and the address strobe is low.
- IDLE→WRITE happens on select and write low while read is high and the address strobe is low.
- IDLE→BLOCK happens on select, read and write all low.
- READ→IDLE happens when select, read or the address strobe goes high. READ→BLOCK happens when write goes low.
- WRITE→IDLE happens when write or select goes high; this is the commit point. WRITE→BLOCK happens when read goes low.
- BLOCK→IDLE happens when select goes high, or when read and write are both high.

On the register side the block presents the latched address, the write data, a one-cycle write pulse and a one-cycle read pulse. It takes the read data back from the register file.

Top module: `hbus_regport`

## Requirements
- R1: While the synchronized address strobe is high, `reg_addr` follows the synchronized bus value. When the strobe falls, the last value is kept, and `reg_addr` does not change while the strobe is low. The reset value is 0.
- R2: Each strobe and bus input passes through two synchronizer flops, and the state machine is registered. An input change applied between clock edges therefore shows at the outputs just after the third rising edge that follows the change.
- R3: A read access has select and read low, write high and the address strobe low. During a read access `bus_oe` is 1 and `bus_out` equals `reg_rdata`.
- R4: `reg_rd` is high for exactly one cycle on each entry to the read state, and never at any other time.
- R5: `bus_oe` falls when select, read or the address strobe goes high. `bus_oe` is 0 whenever no read access is in progress. When `bus_oe` is 0, `bus_out` is 0.
- R6: A write is committed when write or select returns high. The commit is a one-cycle `reg_wr` pulse. With the pulse, `reg_wdata` holds the bus value of the last cycle in which both were low, and `reg_addr` holds the latched address.
- R7: The commit happens only if write and select stayed low together for at least `MIN_WR_CYC` clock cycles (default 2). A shorter pulse commits nothing.
- R8: If read and write are low at the same time, the block neither drives the bus nor commits a write. It stays blocked until select goes high or both strobes are high.
- R9: After reset, `bus_oe`, `reg_rd` and `reg_wr` are 0, `reg_addr` is 0, and the synchronizers hold the idle levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 8 | Shared address/data bus, input side |
| bus_out | output | 8 | Shared bus, output side (read data) |
| bus_oe | output | 1 | Output enable for the bus drivers |
| ale_i | input | 1 | Address strobe, active high |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| reg_addr | output | 8 | Latched register address |
| reg_wdata | output | 8 | Write data to the register file |
| reg_wr | output | 1 | One-cycle write commit pulse |
| reg_rd | output | 1 | One-cycle read start pulse |
| reg_rdata | input | 8 | Read data from the register file |

## Verification
Every output of this block moves just after the third rising edge that follows an input change. This covers the address, the output enable, both pulses and the write data: two edges go to synchronization and one to the state register. The bench applies inputs on falling edges and keeps a behavioural model that delays the raw inputs by two edges before it reacts. It compares the model with the ports on every falling edge, so each check lands half a cycle after the design's result has settled. Directed checks on the output enable look at the second and third falling edges after a strobe change. This pins the latency exactly, and the outcome of each host access is checked after its strobes have fully released.

// File: rtl/hbrp_pkg.sv
package hbrp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_BLOCK = 2'd3
    } port_state_t;

    typedef struct packed {
        logic ale;
        logic cs_n;
        logic rd_n;
        logic wr_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{ale: 1'b0, cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1};
endpackage

// File: rtl/hbrp_sync.sv
module hbrp_sync #(
    parameter int              W         = 4,
    parameter int              STAGES    = 2,
    parameter logic [W-1:0]    RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage[i] <= RESET_VAL;
                else        stage[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage[i] <= RESET_VAL;
                else        stage[i] <= stage[i-1];
            end
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/hbrp_addr.sv
module hbrp_addr #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ale_s,
    input  logic [AW-1:0] bus_s,
    output logic [AW-1:0] addr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     addr <= '0;
        else if (ale_s) addr <= bus_s;
    end

    p_addr_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ale_s) |-> $stable(addr));
endmodule

// File: rtl/hbrp_fsm.sv
module hbrp_fsm
    import hbrp_pkg::*;
#(
    parameter int DW         = 8,
    parameter int MIN_WR_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  strobe_t       stb_s,
    input  logic [DW-1:0] bus_s,
    output logic          bus_oe,
    output logic          reg_rd,
    output logic          reg_wr,
    output logic [DW-1:0] reg_wdata
);
    localparam int             CW      = $clog2(MIN_WR_CYC + 1) < 1 ? 1 : $clog2(MIN_WR_CYC + 1);
    localparam logic [CW-1:0]  CNT_TOP = CW'(MIN_WR_CYC);

    port_state_t   state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          sel, rd_lo, wr_lo;

    assign sel   = !stb_s.cs_n && !stb_s.ale;
    assign rd_lo = !stb_s.rd_n;
    assign wr_lo = !stb_s.wr_n;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sel && rd_lo && wr_lo) state_d = ST_BLOCK;
                else if (sel && rd_lo)     state_d = ST_READ;
                else if (sel && wr_lo)     state_d = ST_WRITE;
            end
            ST_READ: begin
                if (wr_lo)                                      state_d = ST_BLOCK;
                else if (stb_s.cs_n || !rd_lo || stb_s.ale)     state_d = ST_IDLE;
            end
            ST_WRITE: begin
                if (rd_lo)                                      state_d = ST_BLOCK;
                else if (stb_s.cs_n || !wr_lo)                  state_d = ST_IDLE;
            end
            ST_BLOCK: begin
                if (stb_s.cs_n || (!rd_lo && !wr_lo))           state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rd    <= 1'b0;
            reg_wr    <= 1'b0;
            reg_wdata <= '0;
            cnt_q     <= '0;
        end else begin
            reg_rd <= (state_q == ST_IDLE) && (state_d == ST_READ);
            reg_wr <= (state_q == ST_WRITE) && (state_d == ST_IDLE) && (cnt_q == CNT_TOP);
            if (state_d == ST_WRITE) begin
                reg_wdata <= bus_s;
                if (state_q != ST_WRITE)  cnt_q <= CW'(1);
                else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign bus_oe = (state_q == ST_READ);

    p_oe_qualified_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> $past(!stb_s.cs_n && !stb_s.rd_n && stb_s.wr_n && !stb_s.ale));
    p_rd_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |-> $past(!stb_s.cs_n && !stb_s.rd_n && stb_s.wr_n && !stb_s.ale));
    p_rd_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);
    p_wr_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);
    p_wr_on_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> $past(stb_s.cs_n || stb_s.wr_n));
    p_no_wr_conflict_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> $past(stb_s.rd_n));
    p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_rd));
endmodule

// File: rtl/hbus_regport.sv
module hbus_regport
    import hbrp_pkg::*;
#(
    parameter int DW          = 8,
    parameter int MIN_WR_CYC  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe,
    input  logic          ale_i,
    input  logic          cs_ni,
    input  logic          rd_ni,
    input  logic          wr_ni,
    output logic [DW-1:0] reg_addr,
    output logic [DW-1:0] reg_wdata,
    output logic          reg_wr,
    output logic          reg_rd,
    input  logic [DW-1:0] reg_rdata
);
    localparam int AW = DW;

    strobe_t       stb_raw, stb_s;
    logic [DW-1:0] bus_s;

    assign stb_raw = '{ale: ale_i, cs_n: cs_ni, rd_n: rd_ni, wr_n: wr_ni};

    hbrp_sync #(.W($bits(strobe_t)), .STAGES(SYNC_STAGES), .RESET_VAL(STROBE_IDLE)) u_stb_sync (
        .clk(clk), .rst_n(rst_n), .d(stb_raw), .q(stb_s)
    );

    hbrp_sync #(.W(DW), .STAGES(SYNC_STAGES), .RESET_VAL('0)) u_bus_sync (
        .clk(clk), .rst_n(rst_n), .d(bus_in), .q(bus_s)
    );

    hbrp_addr #(.AW(AW)) u_addr (
        .clk(clk), .rst_n(rst_n), .ale_s(stb_s.ale), .bus_s(bus_s), .addr(reg_addr)
    );

    hbrp_fsm #(.DW(DW), .MIN_WR_CYC(MIN_WR_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .stb_s(stb_s), .bus_s(bus_s),
        .bus_oe(bus_oe), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata)
    );

    assign bus_out = bus_oe ? reg_rdata : '0;

    p_out_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (bus_out == '0));
endmodule

// File: tb/hbus_regport_tb_top.sv
module hbus_regport_tb_top;
    localparam int MINW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] bus_in = 8'h00;
    logic ale = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0] bus_out, reg_addr, reg_wdata, reg_rdata;
    logic bus_oe, reg_wr, reg_rd;

    int checks = 0, errors = 0;
    int wr_pulses = 0, rd_pulses = 0, oe_cycles = 0;
    logic [7:0] last_waddr = 8'h00, last_wdata = 8'h00;
    logic [7:0] mem [256];

    always #10 clk = ~clk;

    hbus_regport #(.DW(8), .MIN_WR_CYC(MINW), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .ale_i(ale), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata)
    );

    // simple register file on the internal side
    assign reg_rdata = mem[reg_addr];
    always @(posedge clk) if (reg_wr) mem[reg_addr] <= reg_wdata;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference: raw inputs seen two edges late, access mode tracked
    logic [11:0] dly [$];
    int   m_mode = 0, m_len = 0;
    logic m_oe = 0, m_rd = 0, m_wr = 0;
    logic [7:0] m_addr = 0, m_wdata = 0;

    always @(posedge clk) begin
        logic [11:0] old;
        logic a, c, r, w;
        logic [7:0] b;
        if (!rst_n) begin
            dly = {12'h700, 12'h700};
            m_mode = 0; m_len = 0; m_oe = 0; m_rd = 0; m_wr = 0; m_addr = 0; m_wdata = 0;
        end else begin
            old = dly.pop_front();
            dly.push_back({ale, cs_n, rd_n, wr_n, bus_in});
            {a, c, r, w, b} = old;
            m_rd = 0; m_wr = 0;
            if (a) m_addr = b;
            if (m_mode == 0) begin
                if (!c && !a && !r && !w) m_mode = 3;
                else if (!c && !a && !r) begin m_mode = 1; m_rd = 1; end
                else if (!c && !a && !w) begin m_mode = 2; m_len = 1; m_wdata = b; end
            end else if (m_mode == 1) begin
                if (!w) m_mode = 3;
                else if (c || r || a) m_mode = 0;
            end else if (m_mode == 2) begin
                if (!r) m_mode = 3;
                else if (c || w) begin m_wr = (m_len >= MINW); m_mode = 0; end
                else begin m_len++; m_wdata = b; end
            end else begin
                if (c || (r && w)) m_mode = 0;
            end
            m_oe = (m_mode == 1);
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk(reg_addr == m_addr, "R1", "reg_addr", reg_addr, m_addr);
            chk(bus_oe == m_oe, "R3", "bus_oe", bus_oe, m_oe);
            chk(reg_rd == m_rd, "R4", "reg_rd", reg_rd, m_rd);
            chk(reg_wr == m_wr, "R6", "reg_wr", reg_wr, m_wr);
            if (m_wr) chk(reg_wdata == m_wdata, "R6", "reg_wdata", reg_wdata, m_wdata);
            if (!bus_oe) chk(bus_out == 8'h00, "R5", "bus_out idle", bus_out, 0);
            else chk(bus_out == mem[m_addr], "R3", "bus_out", bus_out, mem[m_addr]);
            if (reg_wr) begin wr_pulses++; last_waddr = reg_addr; last_wdata = reg_wdata; end
            if (reg_rd) rd_pulses++;
            if (bus_oe) oe_cycles++;
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_addr(input logic [7:0] a);
        @(negedge clk); bus_in = a; ale = 1;
        wait_n(3); ale = 0;
        wait_n(3);
    endtask

    task automatic host_write(input logic [7:0] a, input logic [7:0] d, input int n, input bit by_cs);
        set_addr(a);
        bus_in = d; cs_n = 0; wr_n = 0;
        wait_n(n);
        if (by_cs) cs_n = 1; else wr_n = 1;
        wait_n(4);
        cs_n = 1; wr_n = 1; bus_in = 8'h00;
        wait_n(3);
    endtask

    task automatic host_read(input logic [7:0] a, output logic [7:0] got, output logic oe_seen);
        set_addr(a);
        bus_in = 8'h00; cs_n = 0; rd_n = 0;
        wait_n(5);
        got = bus_out; oe_seen = bus_oe;
        rd_n = 1; cs_n = 1;
        wait_n(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] got;
        logic oe_seen;
        int wp, rp, oc;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        wait_n(4);
        // R9 reset state
        chk(bus_oe == 0 && reg_rd == 0 && reg_wr == 0, "R9", "strobes in reset", {bus_oe, reg_rd, reg_wr}, 0);
        chk(reg_addr == 8'h00, "R9", "reg_addr in reset", reg_addr, 0);
        rst_n = 1;
        wait_n(3);

        // R6 write ended by write strobe
        wp = wr_pulses;
        host_write(8'h15, 8'hA7, 4, 0);
        chk(wr_pulses == wp + 1, "R6", "write pulse count", wr_pulses, wp + 1);
        chk(last_waddr == 8'h15 && last_wdata == 8'hA7, "R6", "write addr/data", {last_waddr, last_wdata}, 16'h15A7);

        // R3 R4 read back
        rp = rd_pulses;
        host_read(8'h15, got, oe_seen);
        chk(oe_seen == 1, "R3", "oe during read", oe_seen, 1);
        chk(got == 8'hA7, "R3", "read data", got, 8'hA7);
        chk(rd_pulses == rp + 1, "R4", "read pulse count", rd_pulses, rp + 1);

        // R6 write ended by select
        host_write(8'h40, 8'h3C, 3, 1);
        host_read(8'h40, got, oe_seen);
        chk(got == 8'h3C, "R6", "commit on select release", got, 8'h3C);

        // R7 too short, then exactly minimum
        wp = wr_pulses;
        host_write(8'h40, 8'h99, 1, 0);
        chk(wr_pulses == wp, "R7", "short pulse dropped", wr_pulses, wp);
        host_read(8'h40, got, oe_seen);
        chk(got == 8'h3C, "R7", "value kept after short pulse", got, 8'h3C);
        host_write(8'h40, 8'h5A, MINW, 0);
        host_read(8'h40, got, oe_seen);
        chk(got == 8'h5A, "R7", "minimum pulse commits", got, 8'h5A);

        // R8 read and write together
        wp = wr_pulses; oc = oe_cycles;
        set_addr(8'h15);
        bus_in = 8'h11; cs_n = 0; rd_n = 0; wr_n = 0;
        wait_n(5); rd_n = 1;
        wait_n(4); wr_n = 1;
        wait_n(4); cs_n = 1; bus_in = 0;
        wait_n(4);
        chk(wr_pulses == wp, "R8", "no commit on conflict", wr_pulses, wp);
        chk(oe_cycles == oc, "R8", "no drive on conflict", oe_cycles, oc);

        // R8 read strobe arriving during a write
        set_addr(8'h15);
        bus_in = 8'h22; cs_n = 0; wr_n = 0;
        wait_n(4); rd_n = 0;
        wait_n(3); rd_n = 1; wr_n = 1; cs_n = 1; bus_in = 0;
        wait_n(4);
        chk(wr_pulses == wp, "R8", "no commit after mid-write read", wr_pulses, wp);
        host_read(8'h15, got, oe_seen);
        chk(got == 8'hA7, "R8", "register untouched", got, 8'hA7);

        // R1 last value on falling strobe kept
        @(negedge clk); bus_in = 8'h33; ale = 1;
        wait_n(3); bus_in = 8'h5C;
        wait_n(3); ale = 0;
        wait_n(3); bus_in = 8'hEE;
        wait_n(4);
        chk(reg_addr == 8'h5C, "R1", "address kept after strobe", reg_addr, 8'h5C);

        // R2 latency and R5 release
        bus_in = 8'h00; cs_n = 0; rd_n = 0;
        wait_n(2);
        chk(bus_oe == 0, "R2", "oe not yet after two edges", bus_oe, 0);
        wait_n(1);
        chk(bus_oe == 1, "R2", "oe after third edge", bus_oe, 1);
        ale = 1;
        wait_n(3);
        chk(bus_oe == 0, "R5", "oe dropped by address strobe", bus_oe, 0);
        ale = 0; rd_n = 1; cs_n = 1;
        wait_n(4);
        chk(bus_oe == 0, "R5", "oe idle", bus_oe, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule